// File: doc/BRIEF.md
# Mode-0 Programmable Parallel Port

This block is a three-port parallel I/O peripheral that sits on an 8-bit processor bus. Ports A and B are 8 bits wide. Port C is also 8 bits wide, but its upper and lower nibbles each have their own direction. A two-bit register address selects one of the three port data registers or the write-only control register. A write to the control register does one of two things, chosen by its top bit. It either loads a new port configuration or forces a single port C latch bit to 0 or 1.

Each port has an output latch that always drives its `*_out` pins. An output-enable vector follows the port's direction bit. A read returns the pins for an input port and the latch for an output port. Only the basic (unhandshaked) mode is built. Mode fields that ask for strobed or bidirectional operation are accepted, stored and otherwise ignored.

A compatibility parameter selects the integrated variant of the port. In that variant a configuration write leaves the latches untouched, port B is always an input and port C is always an output.

Top module: `ppp_top`

## Requirements
- R1: Address 0 selects port A data, 1 selects port B data and 2 selects port C data. A selected write loads the whole latch of that port on the next clock edge, and the latch appears on the port's `*_out` pins.
- R2: The control register (address 3) cannot be read. A selected read at address 3 returns 0xFF and changes no latch, output or enable. When `bus_sel` is low, `bus_rdata` is 0x00.
- R3: A control write with bit 7 = 1 is a configuration write. Its direction bits are: bit 4 for port A, bit 1 for port B, bit 0 for lower C and bit 3 for upper C, where 1 means input. An input port has output-enable 0x00 and an output port has 0xFF. Writing 0x82 makes A and all of C outputs and B an input. Writing 0x92 then makes A an input.
- R4: A control write with bit 7 = 0 changes port C latch bit N, where N = bits 3:1, to the value of bit 0. The other latch bits keep their values, and bits 6:4 of the write are ignored.
- R5: With COMPAT = 0, every configuration write clears the latches of A, B and C to 0x00.
- R6: The lower and upper nibbles of port C have independent directions. Reads and enables are resolved per nibble.
- R7: With COMPAT = 1, configuration writes do not clear any latch. Port B is always an input (enable 0x00) and port C is always an output (enable 0xFF), whatever the direction bits say.
- R8: After synchronous reset, all latches are 0x00 and the configuration is 0x9B. With COMPAT = 0 every port is an input.
- R9: A read of an input port (or nibble) returns its pins. A read of an output port returns its latch.
- R10: A write to a port that is an input still updates its latch. That value is driven once the port becomes an output, as long as no clearing configuration write comes in between.
- R11: The mode fields (bit 2 and bits 6:5 of a configuration write) have no effect. 0xE6 behaves exactly like 0x82.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| pa_pins | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A latch drive |
| pa_oe | output | 8 | Port A output enable |
| pb_pins | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B latch drive |
| pb_oe | output | 8 | Port B output enable |
| pc_pins | input | 8 | Port C pin levels |
| pc_out | output | 8 | Port C latch drive |
| pc_oe | output | 8 | Port C output enable, per nibble |

## Verification
The bench builds the block twice, once with COMPAT = 0 and once with COMPAT = 1, and drives both from the same bus and pin stimulus. The same configuration write therefore has to clear the latches in one copy and leave them intact in the other. Port B's and port C's direction bits are obeyed in one copy and overridden in the other. Running the copies side by side also exposes the latch-held value of a port that was written while it was an input and later turned into an output (R10), which the clearing variant hides.

// File: rtl/ppp_pkg.sv
package ppp_pkg;
    localparam int DW   = 8;
    localparam int IDXW = $clog2(DW);

    typedef enum logic [1:0] {
        SEL_A    = 2'b00,
        SEL_B    = 2'b01,
        SEL_C    = 2'b10,
        SEL_CTRL = 2'b11
    } sel_e;

    localparam logic [DW-1:0] CFG_RESET     = 8'h9B;
    localparam logic [DW-1:0] CTRL_READBACK = 8'hFF;

    // direction flags: 1 = input
    typedef struct packed {
        logic [1:0] mode_hi;
        logic       a_in;
        logic       ch_in;
        logic       mode_lo;
        logic       b_in;
        logic       cl_in;
    } cfg_t;

    typedef struct packed {
        logic            cfg_wr;
        logic            bit_wr;
        logic [IDXW-1:0] bit_idx;
        logic            bit_val;
    } ctrl_evt_t;

    function automatic cfg_t cfg_from_byte(input logic [DW-1:0] v);
        cfg_t c;
        c.mode_hi = v[6:5];
        c.a_in    = v[4];
        c.ch_in   = v[3];
        c.mode_lo = v[2];
        c.b_in    = v[1];
        c.cl_in   = v[0];
        return c;
    endfunction

    function automatic logic [DW-1:0] dir_mask(input logic is_in);
        return is_in ? '0 : '1;
    endfunction

    // pins where a nibble is input, latch where it is output
    function automatic logic [DW-1:0] split_read(input logic [DW-1:0] pins,
                                                 input logic [DW-1:0] latch,
                                                 input logic hi_in,
                                                 input logic lo_in);
        logic [DW-1:0] r;
        r[DW-1:DW/2] = hi_in ? pins[DW-1:DW/2] : latch[DW-1:DW/2];
        r[DW/2-1:0]  = lo_in ? pins[DW/2-1:0]  : latch[DW/2-1:0];
        return r;
    endfunction
endpackage

// File: rtl/ppp_ctrl.sv
module ppp_ctrl
    import ppp_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          ctrl_we,
    input  logic [DW-1:0] wdata,
    output cfg_t          cfg,
    output ctrl_evt_t     evt
);
    cfg_t cfg_q;

    always_comb begin
        evt.cfg_wr  = ctrl_we &&  wdata[DW-1];
        evt.bit_wr  = ctrl_we && !wdata[DW-1];
        evt.bit_idx = wdata[IDXW:1];
        evt.bit_val = wdata[0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= cfg_from_byte(CFG_RESET);
        else if (evt.cfg_wr)
            cfg_q <= cfg_from_byte(wdata);
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/ppp_latch.sv
module ppp_latch #(
    parameter int W      = 8,
    parameter bit CLR_EN = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic [W-1:0] ld_mask,
    input  logic [W-1:0] ld_data,
    output logic [W-1:0] q
);
    logic [W-1:0] q_r;

    always_ff @(posedge clk) begin
        if (rst)
            q_r <= '0;
        else if (CLR_EN && clr)
            q_r <= '0;
        else
            q_r <= (q_r & ~ld_mask) | (ld_data & ld_mask);
    end

    assign q = q_r;
endmodule

// File: rtl/ppp_top.sv
module ppp_top
    import ppp_pkg::*;
#(
    parameter bit COMPAT = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_sel,
    input  logic       bus_wr,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic [7:0] pa_pins,
    output logic [7:0] pa_out,
    output logic [7:0] pa_oe,
    input  logic [7:0] pb_pins,
    output logic [7:0] pb_out,
    output logic [7:0] pb_oe,
    input  logic [7:0] pc_pins,
    output logic [7:0] pc_out,
    output logic [7:0] pc_oe
);
    localparam bit CLEAR_ON_CFG = !COMPAT;

    sel_e      sel;
    logic      we_a, we_b, we_c, we_ctrl;
    cfg_t      cfg;
    ctrl_evt_t evt;
    logic      a_in, b_in, cl_in, ch_in;
    logic [DW-1:0] c_mask, c_data;

    assign sel     = sel_e'(bus_addr);
    assign we_a    = bus_sel && bus_wr && (sel == SEL_A);
    assign we_b    = bus_sel && bus_wr && (sel == SEL_B);
    assign we_c    = bus_sel && bus_wr && (sel == SEL_C);
    assign we_ctrl = bus_sel && bus_wr && (sel == SEL_CTRL);

    ppp_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .ctrl_we(we_ctrl),
        .wdata  (bus_wdata),
        .cfg    (cfg),
        .evt    (evt)
    );

    // effective directions; mode fields are never consulted
    assign a_in = cfg.a_in;
    generate
        if (COMPAT) begin : g_fixed_dirs
            assign b_in  = 1'b1;
            assign cl_in = 1'b0;
            assign ch_in = 1'b0;
        end else begin : g_prog_dirs
            assign b_in  = cfg.b_in;
            assign cl_in = cfg.cl_in;
            assign ch_in = cfg.ch_in;
        end
    endgenerate

    ppp_latch #(.W(DW), .CLR_EN(CLEAR_ON_CFG)) u_lat_a (
        .clk(clk), .rst(rst), .clr(evt.cfg_wr),
        .ld_mask({DW{we_a}}), .ld_data(bus_wdata), .q(pa_out)
    );

    ppp_latch #(.W(DW), .CLR_EN(CLEAR_ON_CFG)) u_lat_b (
        .clk(clk), .rst(rst), .clr(evt.cfg_wr),
        .ld_mask({DW{we_b}}), .ld_data(bus_wdata), .q(pb_out)
    );

    always_comb begin
        if (we_c) begin
            c_mask = '1;
            c_data = bus_wdata;
        end else if (evt.bit_wr) begin
            c_mask = DW'(1) << evt.bit_idx;
            c_data = {DW{evt.bit_val}};
        end else begin
            c_mask = '0;
            c_data = '0;
        end
    end

    ppp_latch #(.W(DW), .CLR_EN(CLEAR_ON_CFG)) u_lat_c (
        .clk(clk), .rst(rst), .clr(evt.cfg_wr),
        .ld_mask(c_mask), .ld_data(c_data), .q(pc_out)
    );

    assign pa_oe = dir_mask(a_in);
    assign pb_oe = dir_mask(b_in);
    assign pc_oe = {dir_mask(ch_in)[DW-1:DW/2], dir_mask(cl_in)[DW/2-1:0]};

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            unique case (sel)
                SEL_A:    bus_rdata = a_in ? pa_pins : pa_out;
                SEL_B:    bus_rdata = b_in ? pb_pins : pb_out;
                SEL_C:    bus_rdata = split_read(pc_pins, pc_out, ch_in, cl_in);
                default:  bus_rdata = CTRL_READBACK;
            endcase
        end
    end
endmodule

// File: rtl/ppp_chk.sv
module ppp_chk #(
    parameter bit COMPAT = 1'b0
) (
    input logic       clk,
    input logic       rst,
    input logic       bus_sel,
    input logic       bus_wr,
    input logic [1:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic [7:0] pa_out,
    input logic [7:0] pa_oe,
    input logic [7:0] pb_out,
    input logic [7:0] pb_oe,
    input logic [7:0] pc_out,
    input logic [7:0] pc_oe
);
    logic cfg_w, bit_w, ctrl_rd, a_w;
    assign cfg_w   = bus_sel && bus_wr && bus_addr == 2'b11 &&  bus_wdata[7];
    assign bit_w   = bus_sel && bus_wr && bus_addr == 2'b11 && !bus_wdata[7];
    assign ctrl_rd = bus_sel && !bus_wr && bus_addr == 2'b11;
    assign a_w     = bus_sel && bus_wr && bus_addr == 2'b00;

    p_ctrl_read_r2: assert property (@(posedge clk) disable iff (rst)
        ctrl_rd |-> bus_rdata == 8'hFF);

    p_idle_rdata_r2: assert property (@(posedge clk) disable iff (rst)
        !bus_sel |-> bus_rdata == 8'h00);

    p_ctrl_read_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        ctrl_rd |=> $stable(pa_out) && $stable(pb_out) && $stable(pc_out)
                    && $stable(pa_oe) && $stable(pc_oe));

    p_bit_write_r4: assert property (@(posedge clk) disable iff (rst)
        bit_w |=> pc_out[$past(bus_wdata[3:1])] == $past(bus_wdata[0]));

    p_cfg_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (!COMPAT && cfg_w) |=> pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00);

    p_halves_r6: assert property (@(posedge clk) disable iff (rst)
        (pc_oe[3:0] == 4'h0 || pc_oe[3:0] == 4'hF) &&
        (pc_oe[7:4] == 4'h0 || pc_oe[7:4] == 4'hF));

    p_compat_keep_r7: assert property (@(posedge clk) disable iff (rst)
        (COMPAT && cfg_w) |=> $stable(pa_out) && $stable(pb_out) && $stable(pc_out));

    p_compat_dirs_r7: assert property (@(posedge clk) disable iff (rst)
        COMPAT |-> pb_oe == 8'h00 && pc_oe == 8'hFF);

    p_port_a_load_r10: assert property (@(posedge clk) disable iff (rst)
        a_w |=> pa_out == $past(bus_wdata));
endmodule

bind ppp_top ppp_chk #(.COMPAT(COMPAT)) u_chk (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pa_out(pa_out), .pa_oe(pa_oe), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_out(pc_out), .pc_oe(pc_oe)
);

// File: tb/ppp_top_tb_top.sv
`timescale 1ns/100ps
module ppp_top_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'b00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] pa_pins = 8'h00, pb_pins = 8'h00, pc_pins = 8'h00;

    logic [7:0] rd [2];
    logic [7:0] ao [2], ae [2], bo [2], be [2], co [2], ce [2];

    int total = 0;
    int bad = 0;

    // model state: [instance][port A,B,C]; dirs [instance][A,B,CL,CH], 1 = input
    logic [7:0] m_lat [2][3];
    logic       m_dir [2][4];

    always #2 clk = ~clk;

    ppp_top #(.COMPAT(1'b0)) dut_i (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd[0]),
        .pa_pins(pa_pins), .pa_out(ao[0]), .pa_oe(ae[0]),
        .pb_pins(pb_pins), .pb_out(bo[0]), .pb_oe(be[0]),
        .pc_pins(pc_pins), .pc_out(co[0]), .pc_oe(ce[0])
    );

    ppp_top #(.COMPAT(1'b1)) dut_compat_i (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd[1]),
        .pa_pins(pa_pins), .pa_out(ao[1]), .pa_oe(ae[1]),
        .pb_pins(pb_pins), .pb_out(bo[1]), .pb_oe(be[1]),
        .pc_pins(pc_pins), .pc_out(co[1]), .pc_oe(ce[1])
    );

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    function automatic logic eff_in(input int k, input int p);
        if (k == 1 && p == 1) return 1'b1;          // R7 B forced input
        if (k == 1 && p >= 2) return 1'b0;          // R7 C forced output
        return m_dir[k][p];
    endfunction

    function automatic logic [7:0] exp_rd(input int k, input int a);
        case (a)
            0: return eff_in(k, 0) ? pa_pins : m_lat[k][0];
            1: return eff_in(k, 1) ? pb_pins : m_lat[k][1];
            2: return {eff_in(k, 3) ? pc_pins[7:4] : m_lat[k][2][7:4],
                       eff_in(k, 2) ? pc_pins[3:0] : m_lat[k][2][3:0]};
            default: return 8'hFF;
        endcase
    endfunction

    task automatic check_all(input string req);
        for (int k = 0; k < 2; k++) begin
            chk(req, "pa_out", ao[k], m_lat[k][0]);
            chk(req, "pb_out", bo[k], m_lat[k][1]);
            chk(req, "pc_out", co[k], m_lat[k][2]);
            chk(req, "pa_oe", ae[k], eff_in(k, 0) ? 8'h00 : 8'hFF);
            chk(req, "pb_oe", be[k], eff_in(k, 1) ? 8'h00 : 8'hFF);
            chk(req, "pc_oe", ce[k], {eff_in(k, 3) ? 4'h0 : 4'hF, eff_in(k, 2) ? 4'h0 : 4'hF});
        end
        #0.5;
        chk("R2", "idle rdata", rd[0], 8'h00);
        for (int a = 0; a < 4; a++) begin
            bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 2'(a);
            #0.5;
            for (int k = 0; k < 2; k++)
                chk(a == 3 ? "R2" : "R9", $sformatf("read%0d inst%0d", a, k), rd[k], exp_rd(k, a));
        end
        bus_sel = 1'b0;
    endtask

    task automatic do_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        for (int k = 0; k < 2; k++) begin
            if (a != 2'd3) m_lat[k][a] = d;
            else if (d[7]) begin
                m_dir[k][0] = d[4]; m_dir[k][1] = d[1];
                m_dir[k][2] = d[0]; m_dir[k][3] = d[3];
                if (k == 0) begin m_lat[0][0] = 8'h00; m_lat[0][1] = 8'h00; m_lat[0][2] = 8'h00; end
            end else m_lat[k][2][d[3:1]] = d[0];
        end
    endtask

    initial begin
        #(200000 * 4);
        total++; bad++;
        $display("watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int k = 0; k < 2; k++) begin
            for (int p = 0; p < 3; p++) m_lat[k][p] = 8'h00;
            m_dir[k][0] = 1'b1; m_dir[k][1] = 1'b1; m_dir[k][2] = 1'b1; m_dir[k][3] = 1'b1;
        end
        pa_pins = 8'hA1; pb_pins = 8'hB2; pc_pins = 8'hC3;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_all("R8");
        chk("R8", "reset pc_oe", ce[0], 8'h00);

        do_write(2'd3, 8'h82); check_all("R3");
        chk("R3", "0x82 pa_oe", ae[0], 8'hFF);
        chk("R3", "0x82 pb_oe", be[0], 8'h00);
        do_write(2'd0, 8'h5A); check_all("R1");
        do_write(2'd1, 8'h3C); check_all("R1");
        do_write(2'd2, 8'h00); check_all("R1");
        do_write(2'd3, 8'h0F); check_all("R4");
        chk("R4", "bit7 set", co[0], 8'h80);
        do_write(2'd3, 8'h05); check_all("R4");
        do_write(2'd3, 8'h7E); check_all("R4");
        chk("R4", "bit7 cleared, 6:4 ignored", co[0], 8'h04);
        do_write(2'd3, 8'h92); check_all("R5");
        chk("R5", "A cleared", ao[0], 8'h00);
        chk("R7", "compat A kept", ao[1], 8'h5A);
        chk("R3", "0x92 pa_oe", ae[0], 8'h00);
        do_write(2'd3, 8'h81); check_all("R6");
        chk("R6", "lower in upper out", ce[0], 8'hF0);
        do_write(2'd3, 8'h88); check_all("R6");
        chk("R6", "upper in lower out", ce[0], 8'h0F);
        do_write(2'd3, 8'hE6); check_all("R11");
        chk("R11", "0xE6 like 0x82 pa_oe", ae[0], 8'hFF);
        chk("R11", "0xE6 like 0x82 pc_oe", ce[0], 8'hFF);
        do_write(2'd3, 8'h90);
        do_write(2'd0, 8'hC3); check_all("R10");
        chk("R10", "latch while input", ao[0], 8'hC3);
        do_write(2'd3, 8'h80); check_all("R10");
        chk("R10", "compat drives held value", ao[1], 8'hC3);
        chk("R7", "compat pb_oe", be[1], 8'h00);

        for (int i = 0; i < 400; i++) begin
            logic [1:0] a;
            logic [7:0] d;
            pa_pins = 8'($urandom); pb_pins = 8'($urandom); pc_pins = 8'($urandom);
            a = 2'($urandom);
            d = 8'($urandom);
            do_write(a, d);
            check_all("R1 R9");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule